// File: doc/BRIEF.md
# Directory-Protocol Cache Line Controller

This block is the cache side of one node in a directory-based coherent multiprocessor. It keeps a small direct-mapped array of lines, each with a coherence state, a tag and one data word. It serves a blocking processor port. A hit completes in one cycle. A miss sends a request message to the home node of the address and waits for the data reply. If the victim line holds modified data, the block first sends that data back to its own home node.

The block also takes targeted coherence requests from home directories. These are invalidate, fetch, and fetch-with-invalidate. It answers them by changing the line state and, where the line is owned, by sending a data write-back message. The home node of any address is its upper `NODE_W` address bits. Messages are assumed to be delivered in order. The directory and the network are outside the block.

Top module: `dir_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, and `out_valid`, `cpu_done` and `busy` are low.
- R2: A read that hits a Shared or Exclusive line, or a write that hits an Exclusive line, sends no message. For that access `cpu_done` pulses for one cycle, with the line data on `cpu_rdata` (for a write, the new data).
- R3: A read to a line that is absent sends one read-miss message (`out_type` 0). Its `out_dest` is the upper `NODE_W` bits of the address and its `out_src` is `NODE_ID`. The reply data is returned, and the line is installed as Shared: a later read hits, and a later write sends a write miss.
- R4: A write to a line that is absent or Shared sends one write-miss message (`out_type` 1). After the reply, the line is Exclusive and holds the written word, so a following write or read of it sends no message.
- R5: A miss whose victim line is Exclusive under another tag first sends a write-back (`out_type` 2) carrying the old address and old data. The miss message follows in a later cycle. This applies to both read and write misses.
- R6: `busy` is high from the cycle the miss message is presented until the cycle `cpu_done` reports the reply, and is low in that cycle.
- R7: An inbound invalidate (`in_type` 0) that matches a Shared line makes it Invalid, and the next read misses. An invalidate to an Exclusive line, or one whose tag does not match, changes nothing and sends nothing.
- R8: An inbound fetch (`in_type` 1) that matches an Exclusive line sends a write-back of its data in the next cycle and leaves the line Shared.
- R9: An inbound fetch-with-invalidate (`in_type` 2) that matches an Exclusive line sends a write-back of its data and leaves the line Invalid.
- R10: A fetch to a line that is not Exclusive, or whose tag does not match, sends no message and changes no state.
- R11: A data reply (`in_type` 3) that arrives with no miss outstanding is ignored, and `cpu_done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Processor address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_done | output | 1 | Access complete (one-cycle pulse) |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_done` |
| busy | output | 1 | Miss outstanding |
| in_valid | input | 1 | Inbound message valid |
| in_type | input | 2 | 0 invalidate, 1 fetch, 2 fetch-invalidate, 3 data reply |
| in_addr | input | ADDR_W | Inbound message address |
| in_data | input | DATA_W | Inbound reply data |
| out_valid | output | 1 | Outbound message valid |
| out_type | output | 2 | 0 read miss, 1 write miss, 2 write-back |
| out_dest | output | NODE_W | Home node of `out_addr` |
| out_src | output | NODE_W | This node's number |
| out_addr | output | ADDR_W | Message address |
| out_data | output | DATA_W | Write-back data |

## Verification
The hardest case to reach is a write-back forced by a victim line. It needs a line that was first made Exclusive, either by a write miss or by a write to a Shared copy. A second access must then use the same index under a different tag. The bench builds that history on every index with an answering directory model. It then checks that the write-back (old address, old data) comes before the miss, and that fetch and invalidate requests land on lines in each of the three states.

// File: rtl/clc_pkg.sv
package clc_pkg;
  typedef enum logic [1:0] {LS_INV = 2'd0, LS_SHD = 2'd1, LS_EXC = 2'd2} line_st_e;
  localparam logic [1:0] OM_RDMISS = 2'd0;
  localparam logic [1:0] OM_WRMISS = 2'd1;
  localparam logic [1:0] OM_WBACK  = 2'd2;
  localparam logic [1:0] IM_INV      = 2'd0;
  localparam logic [1:0] IM_FETCH    = 2'd1;
  localparam logic [1:0] IM_FETCHINV = 2'd2;
  localparam logic [1:0] IM_REPLY    = 2'd3;
endpackage

// File: rtl/clc_line_store.sv
module clc_line_store
  import clc_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  ra_idx,
  output line_st_e          ra_state,
  output logic [TAG_W-1:0]  ra_tag,
  output logic [DATA_W-1:0] ra_data,
  input  logic [IDX_W-1:0]  rb_idx,
  output line_st_e          rb_state,
  output logic [TAG_W-1:0]  rb_tag,
  output logic [DATA_W-1:0] rb_data,
  input  logic              we,
  input  logic [IDX_W-1:0]  w_idx,
  input  line_st_e          w_state,
  input  logic [TAG_W-1:0]  w_tag,
  input  logic [DATA_W-1:0] w_data
);
  localparam int LINES = 1 << IDX_W;

  line_st_e          st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  // state array resets; tag and data arrays are plain RAM
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= LS_INV;
    end else if (we) begin
      st_q[w_idx] <= w_state;
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      tag_q[w_idx]  <= w_tag;
      data_q[w_idx] <= w_data;
    end
  end

  assign ra_state = st_q[ra_idx];
  assign ra_tag   = tag_q[ra_idx];
  assign ra_data  = data_q[ra_idx];
  assign rb_state = st_q[rb_idx];
  assign rb_tag   = tag_q[rb_idx];
  assign rb_data  = data_q[rb_idx];
endmodule

// File: rtl/clc_coh_resp.sv
module clc_coh_resp
  import clc_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic             in_valid,
  input  logic [1:0]       in_type,
  input  logic [TAG_W-1:0] in_tag,
  input  line_st_e         line_state,
  input  logic [TAG_W-1:0] line_tag,
  output logic             coh_msg,
  output logic             upd,
  output logic             send_wb,
  output line_st_e         new_state
);
  logic match;

  assign coh_msg = in_valid && (in_type != IM_REPLY);
  assign match   = (line_state != LS_INV) && (line_tag == in_tag);

  always_comb begin
    upd       = 1'b0;
    send_wb   = 1'b0;
    new_state = line_state;
    if (coh_msg && match) begin
      case (in_type)
        IM_INV: if (line_state == LS_SHD) begin
          upd = 1'b1; new_state = LS_INV;
        end
        IM_FETCH: if (line_state == LS_EXC) begin
          upd = 1'b1; send_wb = 1'b1; new_state = LS_SHD;
        end
        IM_FETCHINV: if (line_state == LS_EXC) begin
          upd = 1'b1; send_wb = 1'b1; new_state = LS_INV;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dir_cache_ctrl.sv
module dir_cache_ctrl
  import clc_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int IDX_W   = 2,
  parameter int NODE_W  = 2,
  parameter int NODE_ID = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              busy,
  input  logic              in_valid,
  input  logic [1:0]        in_type,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [1:0]        out_type,
  output logic [NODE_W-1:0] out_dest,
  output logic [NODE_W-1:0] out_src,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef enum logic [2:0] {F_IDLE, F_WBACK, F_MISS, F_WAIT, F_DONE} fsm_e;

  fsm_e              st;
  logic              rq_we;
  logic [ADDR_W-1:0] rq_addr;
  logic [DATA_W-1:0] rq_wdata;

  logic [IDX_W-1:0]  ra_idx;
  line_st_e          ra_state, rb_state, w_state, coh_state;
  logic [TAG_W-1:0]  ra_tag, rb_tag, w_tag;
  logic [DATA_W-1:0] ra_data, rb_data, w_data;
  logic [IDX_W-1:0]  w_idx;
  logic              we, coh_msg, coh_upd, coh_wb, hit, reply;

  function automatic logic [NODE_W-1:0] home_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: NODE_W];
  endfunction

  assign ra_idx = (st == F_IDLE) ? cpu_addr[IDX_W-1:0] : rq_addr[IDX_W-1:0];
  assign reply  = in_valid && (in_type == IM_REPLY) && (st == F_WAIT);
  assign hit    = (ra_tag == cpu_addr[ADDR_W-1:IDX_W]) &&
                  (cpu_we ? (ra_state == LS_EXC) : (ra_state != LS_INV));

  clc_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst),
    .ra_idx(ra_idx), .ra_state(ra_state), .ra_tag(ra_tag), .ra_data(ra_data),
    .rb_idx(in_addr[IDX_W-1:0]), .rb_state(rb_state), .rb_tag(rb_tag), .rb_data(rb_data),
    .we(we), .w_idx(w_idx), .w_state(w_state), .w_tag(w_tag), .w_data(w_data)
  );

  clc_coh_resp #(.TAG_W(TAG_W)) u_coh (
    .in_valid(in_valid), .in_type(in_type), .in_tag(in_addr[ADDR_W-1:IDX_W]),
    .line_state(rb_state), .line_tag(rb_tag),
    .coh_msg(coh_msg), .upd(coh_upd), .send_wb(coh_wb), .new_state(coh_state)
  );

  // single write port: inbound requests win, the processor side stalls
  always_comb begin
    we      = 1'b0;
    w_idx   = ra_idx;
    w_state = ra_state;
    w_tag   = ra_tag;
    w_data  = ra_data;
    if (coh_upd) begin
      we      = 1'b1;
      w_idx   = in_addr[IDX_W-1:0];
      w_state = coh_state;
      w_tag   = rb_tag;
      w_data  = rb_data;
    end else begin
      case (st)
        F_IDLE: if (cpu_req && !coh_msg && hit && cpu_we) begin
          we = 1'b1; w_state = LS_EXC; w_data = cpu_wdata;
        end
        F_WBACK: if (!coh_msg && ra_state == LS_EXC) begin
          we = 1'b1; w_state = LS_INV;
        end
        F_WAIT: if (reply) begin
          we      = 1'b1;
          w_state = rq_we ? LS_EXC : LS_SHD;
          w_tag   = rq_addr[ADDR_W-1:IDX_W];
          w_data  = rq_we ? rq_wdata : in_data;
        end
        default: ;
      endcase
    end
  end

  assign out_src = NODE_W'(NODE_ID);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= F_IDLE;
      busy      <= 1'b0;
      cpu_done  <= 1'b0;
      cpu_rdata <= '0;
      out_valid <= 1'b0;
      out_type  <= OM_RDMISS;
      out_dest  <= '0;
      out_addr  <= '0;
      out_data  <= '0;
      rq_we     <= 1'b0;
      rq_addr   <= '0;
      rq_wdata  <= '0;
    end else begin
      out_valid <= 1'b0;
      cpu_done  <= 1'b0;
      if (coh_wb) begin
        out_valid <= 1'b1;
        out_type  <= OM_WBACK;
        out_addr  <= {rb_tag, in_addr[IDX_W-1:0]};
        out_dest  <= home_of({rb_tag, in_addr[IDX_W-1:0]});
        out_data  <= rb_data;
      end
      case (st)
        F_IDLE: if (cpu_req && !coh_msg) begin
          rq_we    <= cpu_we;
          rq_addr  <= cpu_addr;
          rq_wdata <= cpu_wdata;
          if (hit) begin
            cpu_done  <= 1'b1;
            cpu_rdata <= cpu_we ? cpu_wdata : ra_data;
            st        <= F_DONE;
          end else if (ra_state == LS_EXC) begin
            st <= F_WBACK;
          end else begin
            st <= F_MISS;
          end
        end
        F_WBACK: if (!coh_msg) begin
          if (ra_state == LS_EXC) begin
            out_valid <= 1'b1;
            out_type  <= OM_WBACK;
            out_addr  <= {ra_tag, rq_addr[IDX_W-1:0]};
            out_dest  <= home_of({ra_tag, rq_addr[IDX_W-1:0]});
            out_data  <= ra_data;
          end
          st <= F_MISS;
        end
        F_MISS: if (!coh_msg) begin
          out_valid <= 1'b1;
          out_type  <= rq_we ? OM_WRMISS : OM_RDMISS;
          out_addr  <= rq_addr;
          out_dest  <= home_of(rq_addr);
          out_data  <= '0;
          busy      <= 1'b1;
          st        <= F_WAIT;
        end
        F_WAIT: if (reply) begin
          cpu_done  <= 1'b1;
          cpu_rdata <= rq_we ? rq_wdata : in_data;
          busy      <= 1'b0;
          st        <= F_DONE;
        end
        default: st <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dir_cache_ctrl_chk.sv
module dir_cache_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       cpu_done,
  input logic       busy,
  input logic       out_valid,
  input logic [1:0] out_type
);
  // R6
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (out_valid && out_type != 2'd2));
  // R6
  busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> cpu_done);
  // R6
  miss_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_type != 2'd2) |-> busy);
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_done |-> !busy);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_done |=> !cpu_done);
endmodule

bind dir_cache_ctrl dir_cache_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .cpu_done(cpu_done), .busy(busy),
  .out_valid(out_valid), .out_type(out_type)
);

// File: tb/dir_cache_ctrl_tb.sv
module dir_cache_ctrl_tb;
  logic clk = 0, rst = 1;
  logic cpu_req = 0, cpu_we = 0;
  logic [7:0] cpu_addr = 0, cpu_wdata = 0, cpu_rdata;
  logic cpu_done, busy;
  logic in_valid = 0;
  logic [1:0] in_type = 0;
  logic [7:0] in_addr = 0, in_data = 0;
  logic out_valid;
  logic [1:0] out_type, out_dest, out_src;
  logic [7:0] out_addr, out_data;
  int checks = 0, errors = 0, cycles = 0;

  always #5 clk = ~clk;

  dir_cache_ctrl u_dut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata), .busy(busy),
    .in_valid(in_valid), .in_type(in_type), .in_addr(in_addr), .in_data(in_data),
    .out_valid(out_valid), .out_type(out_type), .out_dest(out_dest), .out_src(out_src),
    .out_addr(out_addr), .out_data(out_data)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [7:0] mem_val(input logic [7:0] a);
    return a ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // processor access with an answering home directory
  task automatic access(input logic we, input logic [7:0] a, input logic [7:0] wd,
                        output logic [7:0] rd, output int nwb, output int nmiss,
                        output logic [1:0] mtype, output logic [7:0] wba,
                        output logic [7:0] wbd, output bit order_ok);
    nwb = 0; nmiss = 0; mtype = 0; wba = 0; wbd = 0; order_ok = 1; rd = 0;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      in_valid = 0;
      if (out_valid) begin
        if (out_type == 2'd2) begin
          nwb++; wba = out_addr; wbd = out_data;
          if (nmiss > 0) order_ok = 0;
        end else begin
          nmiss++; mtype = out_type;
          chk(out_dest == a[7:6], "R3 dest", out_dest, a[7:6]);
          chk(out_src == 2'd1, "R3 src", out_src, 1);
          chk(busy == 1'b1, "R6 busy at miss", busy, 1);
          in_valid = 1; in_type = 2'd3; in_addr = out_addr; in_data = mem_val(out_addr);
        end
      end
      if (cpu_done) begin
        rd = cpu_rdata;
        chk(busy == 1'b0, "R6 busy low at done", busy, 0);
        break;
      end
    end
    cpu_req = 0; in_valid = 0;
  endtask

  task automatic coh(input logic [1:0] t, input logic [7:0] a,
                     output bit got, output logic [7:0] wba, output logic [7:0] wbd);
    @(negedge clk);
    in_valid = 1; in_type = t; in_addr = a; in_data = 8'hEE;
    @(negedge clk);
    in_valid = 0;
    got = out_valid && out_type == 2'd2; wba = out_addr; wbd = out_data;
    if (out_valid && out_type != 2'd2) got = 1;
  endtask

  initial begin
    logic [7:0] rd, wba, wbd, a, b, d;
    logic [1:0] mt;
    int nwb, nm;
    bit ok, got;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!out_valid && !cpu_done && !busy, "R1 reset outputs", {out_valid, cpu_done, busy}, 0);

    for (int idx = 0; idx < 4; idx++) begin
      a = {6'(8 + idx * 13), 2'(idx)};
      b = {a[7:2] ^ 6'h2A, 2'(idx)};
      d = 8'h30 + 8'(idx);
      // R1/R3: first read misses, installs Shared
      access(0, a, 0, rd, nwb, nm, mt, wba, wbd, ok);
      chk(nm == 1 && mt == 2'd0 && nwb == 0, "R3 read miss", nm, 1);
      chk(rd == mem_val(a), "R3 reply data", rd, mem_val(a));
      // R2 read hit in Shared
      access(0, a, 0, rd, nwb, nm, mt, wba, wbd, ok);
      chk(nm == 0 && nwb == 0 && rd == mem_val(a), "R2 shared hit", rd, mem_val(a));
      // R7 mismatched invalidate has no effect
      coh(2'd0, b, got, wba, wbd);
      chk(!got, "R7 mismatch inv silent", got, 0);
      access(0, a, 0, rd, nwb, nm, mt, wba, wbd, ok);
      chk(nm == 0, "R7 mismatch inv keeps line", nm, 0);
      // R4 write to Shared -> write miss
      access(1, a, d, rd, nwb, nm, mt, wba, wbd, ok);
      chk(nm == 1 && mt == 2'd1 && nwb == 0, "R4 write miss from shared", mt, 1);
      access(1, a, d + 8'h40, rd, nwb, nm, mt, wba, wbd, ok);
      chk(nm == 0 && nwb == 0, "R4 exclusive write hit", nm, 0);
      access(0, a, 0, rd, nwb, nm, mt, wba, wbd, ok);
      chk(nm == 0 && rd == d + 8'h40, "R2 exclusive read hit", rd, d + 8'h40);
      // R7 invalidate to Exclusive ignored
      coh(2'd0, a, got, wba, wbd);
      chk(!got, "R7 inv on exclusive silent", got, 0);
      access(1, a, d + 8'h41, rd, nwb, nm, mt, wba, wbd, ok);
      chk(nm == 0, "R7 exclusive kept", nm, 0);
      // R8 fetch -> write-back, Shared
      coh(2'd1, a, got, wba, wbd);
      chk(got && wba == a && wbd == d + 8'h41, "R8 fetch write-back", wbd, d + 8'h41);
      access(0, a, 0, rd, nwb, nm, mt, wba, wbd, ok);
      chk(nm == 0 && rd == d + 8'h41, "R8 shared after fetch", nm, 0);
      // R10 fetch on Shared silent
      coh(2'd1, a, got, wba, wbd);
      chk(!got, "R10 fetch on shared", got, 0);
      coh(2'd2, b, got, wba, wbd);
      chk(!got, "R10 fetch-inv mismatch", got, 0);
      access(1, a, d + 8'h42, rd, nwb, nm, mt, wba, wbd, ok);
      chk(nm == 1 && mt == 2'd1 && nwb == 0, "R8 write after fetch misses", nm, 1);
      // R5 read miss displacing Exclusive
      access(0, b, 0, rd, nwb, nm, mt, wba, wbd, ok);
      chk(nwb == 1 && wba == a && wbd == d + 8'h42, "R5 victim write-back", wbd, d + 8'h42);
      chk(nm == 1 && mt == 2'd0 && ok, "R5 order wb then read miss", nm, 1);
      chk(rd == mem_val(b), "R3 displacing read data", rd, mem_val(b));
      // write A displacing Shared B: no write-back
      access(1, a, d + 8'h43, rd, nwb, nm, mt, wba, wbd, ok);
      chk(nwb == 0 && nm == 1 && mt == 2'd1, "R4 write displacing shared", nwb, 0);
      // R9 fetch-invalidate
      coh(2'd2, a, got, wba, wbd);
      chk(got && wba == a && wbd == d + 8'h43, "R9 fetch-inv write-back", wbd, d + 8'h43);
      access(0, a, 0, rd, nwb, nm, mt, wba, wbd, ok);
      chk(nm == 1 && nwb == 0, "R9 invalid after fetch-inv", nm, 1);
      // R7 invalidate Shared
      coh(2'd0, a, got, wba, wbd);
      chk(!got, "R7 inv no message", got, 0);
      access(0, a, 0, rd, nwb, nm, mt, wba, wbd, ok);
      chk(nm == 1 && mt == 2'd0, "R7 invalidated line misses", nm, 1);
      // R5 write miss displacing Exclusive
      access(1, b, d + 8'h44, rd, nwb, nm, mt, wba, wbd, ok);
      access(1, a, d + 8'h45, rd, nwb, nm, mt, wba, wbd, ok);
      chk(nwb == 1 && wba == b && wbd == d + 8'h44 && ok && mt == 2'd1,
          "R5 write displacing exclusive", wbd, d + 8'h44);
      // R11 stray reply ignored
      @(negedge clk);
      in_valid = 1; in_type = 2'd3; in_addr = a; in_data = 8'h00;
      @(negedge clk);
      in_valid = 0;
      chk(!cpu_done && !out_valid, "R11 stray reply", cpu_done, 0);
      access(0, a, 0, rd, nwb, nm, mt, wba, wbd, ok);
      chk(nm == 0 && rd == d + 8'h45, "R11 line unchanged", rd, d + 8'h45);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule